// File: doc/BRIEF.md
# Serial Register Port Slave

This block is the serial slave that sits between an external host and the register space of a chip. The host drives a four-wire serial link: an active-low chip select, a serial clock that idles low, a data line into the block and a data line out of it. Every transaction opens with one direction bit and a seven-bit address. In a write, data bytes follow. In a read, the slave returns register contents on the data-out line. While chip select stays low, further bytes form a burst that walks through consecutive addresses. The one exception is the top address, 7Fh, which acts as a FIFO port. A burst there keeps the address fixed, so bytes stream into a transmit FIFO or out of a receive FIFO.

The serial pins pass through synchronisers and are sampled by the fast system clock. Each serial-clock phase must last at least six system-clock cycles. On the core side the block drives single-cycle strobes. A register write strobe and a FIFO push strobe share one address and data bus. A register read strobe expects `rf_rdata` to be valid in the same cycle, as it would be from a combinational register-file read. The FIFO is show-ahead: `fifo_rdata` holds the head entry, and a pop strobe advances it.

Top module: `spi_reg_slave`

## Requirements
- R1: A transaction sends its bits most significant first. The first bit is the direction: 1 means write and 0 means read. The next seven bits are the target address.
- R2: In a write to any address other than 7Fh, each completed eight-bit data byte raises `rf_wr` for exactly one cycle. In that cycle `rf_addr` holds the target address and `rf_wdata` holds the byte.
- R3: In a read, the byte at the target address appears on `spi_miso`, most significant bit first. The line changes only after falling serial-clock edges, so each bit is valid at the next rising edge. The first bit is valid at the first rising edge after the address. Bits the host sends on `spi_mosi` during a read produce no write or push strobe.
- R4: In a burst at an address other than 7Fh, each further byte goes to the previous address plus one. A burst that starts at 7Eh continues at 7Fh.
- R5: In a write at 7Fh, each completed byte raises `fifo_push` instead of `rf_wr`, with the byte on `rf_wdata`. The address stays at 7Fh for the whole burst.
- R6: In a read at 7Fh, each byte comes from `fifo_rdata`. Each byte that is fully clocked out raises `fifo_pop` once. A byte cut short by chip select produces no pop.
- R7: A data byte cut off by chip select going high is discarded and produces no strobe.
- R8: While chip select is high, the bit counter is held in reset and `spi_miso` and `spi_miso_oe` are low. `spi_miso_oe` is high while chip select is low. The next transaction starts again with a direction bit.
- R9: After reset, every strobe is low and `spi_miso` and `spi_miso_oe` are low.
- R10: At most one of `rf_wr`, `rf_rd`, `fifo_push` and `fifo_pop` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Enable for the data-out pad driver |
| rf_addr | output | 7 | Address for register read, register write and FIFO push |
| rf_wdata | output | 8 | Write data for a register write or FIFO push |
| rf_wr | output | 1 | Register write strobe |
| rf_rd | output | 1 | Register read strobe |
| rf_rdata | input | 8 | Register read data, valid in the cycle of `rf_rd` |
| fifo_push | output | 1 | Push strobe for the transmit FIFO |
| fifo_pop | output | 1 | Pop strobe for the receive FIFO |
| fifo_rdata | input | 8 | Head entry of the receive FIFO |

## Verification
Single-byte writes and reads check the direction bit and the basic byte framing. Multi-byte bursts that start mid-range and at 7Eh separate plain address stepping from the freeze at 7Fh. A burst that starts at 7Fh separates FIFO pushes and pops from register strobes. Reads run with the data-in line held high, so a slave that took the ignored field as write data would show a spurious strobe. Transactions cut off mid-byte, in both directions, show whether a partial byte leaks a write or a pop. A follow-up read after the cut-off read shows that the FIFO head did not advance.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Framing phase of the serial transaction
  typedef enum logic [1:0] {
    PH_HDR = 2'd0,   // direction bit plus address
    PH_WR  = 2'd1,   // write data bytes
    PH_RD  = 2'd2    // read data bytes
  } frame_phase_t;

  // Strobe selector for the core-side bus
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_REG  = 2'd1,
    OP_FIFO = 2'd2
  } op_target_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);

  localparam int PW = 3;
  localparam int CW = STAGES * PW;
  localparam logic [PW-1:0] PIN_IDLE = 3'b100;

  logic [CW-1:0] chain_q, chain_d;
  logic [PW-1:0] newest;
  logic          sclk_dly_q, sclk_dly_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[CW-PW-1:0], cs_n, sclk, mosi};
    end else begin : g_single
      always_comb chain_d = {cs_n, sclk, mosi};
    end
  endgenerate

  always_comb begin
    newest     = chain_q[CW-1 -: PW];
    sclk_dly_d = newest[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= {STAGES{PIN_IDLE}};
      sclk_dly_q <= 1'b0;
    end else begin
      chain_q    <= chain_d;
      sclk_dly_q <= sclk_dly_d;
    end
  end

  assign cs_act    = ~newest[2];
  assign sclk_rise =  newest[1] & ~sclk_dly_q;
  assign sclk_fall = ~newest[1] &  sclk_dly_q;
  assign mosi_s    =  newest[0];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int          DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              rd_load,
  output logic              rd_sel_fifo,
  output logic              tx_shift
);

  localparam int HDR_BITS = ADDR_W + 1;
  localparam int SH_W     = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W    = $clog2(SH_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  frame_phase_t      phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_bit;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pend_q, pend_d;
  logic              cur_fifo_q, cur_fifo_d;

  logic [ADDR_W-1:0] op_addr_q, op_addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  op_target_t        wr_tgt_d, rd_tgt_d;
  logic              wr_q, rd_q, push_q, pop_q, load_q, sel_q, shift_q;
  logic              pop_d, load_d, sel_d, shift_d;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return (a == FIFO_ADDR) ? a : a + ADDR_W'(1);
  endfunction

  assign last_bit = (phase_q == PH_HDR) ? HDR_LAST : DATA_LAST;

  // Next-state logic
  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    addr_d     = addr_q;
    pend_d     = pend_q;
    cur_fifo_d = cur_fifo_q;
    op_addr_d  = op_addr_q;
    wdata_d    = wdata_q;
    wr_tgt_d   = OP_NONE;
    rd_tgt_d   = OP_NONE;
    pop_d      = 1'b0;
    load_d     = 1'b0;
    sel_d      = sel_q;
    shift_d    = 1'b0;

    if (!cs_act) begin
      phase_d    = PH_HDR;
      cnt_d      = '0;
      sh_d       = '0;
      pend_d     = 1'b0;
      cur_fifo_d = 1'b0;
    end else begin
      if (sclk_rise) begin
        sh_d = {sh_q[SH_W-2:0], mosi_s};
        if (cnt_q == last_bit) begin
          cnt_d = '0;
          unique case (phase_q)
            PH_HDR: begin
              addr_d  = sh_d[ADDR_W-1:0];
              if (sh_d[HDR_BITS-1]) begin
                phase_d = PH_WR;
              end else begin
                phase_d = PH_RD;
                pend_d  = 1'b1;
              end
            end
            PH_WR: begin
              op_addr_d = addr_q;
              wdata_d   = sh_d[DATA_W-1:0];
              wr_tgt_d  = (addr_q == FIFO_ADDR) ? OP_FIFO : OP_REG;
              addr_d    = step_addr(addr_q);
            end
            PH_RD: begin
              pend_d = 1'b1;
              if (cur_fifo_q) begin
                pop_d     = 1'b1;
                op_addr_d = FIFO_ADDR;
              end
            end
            default: phase_d = PH_HDR;
          endcase
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end

      if (sclk_fall) begin
        if (pend_q) begin
          pend_d     = 1'b0;
          load_d     = 1'b1;
          sel_d      = (addr_q == FIFO_ADDR);
          cur_fifo_d = (addr_q == FIFO_ADDR);
          rd_tgt_d   = (addr_q == FIFO_ADDR) ? OP_FIFO : OP_REG;
          op_addr_d  = addr_q;
          addr_d     = step_addr(addr_q);
        end else begin
          shift_d = 1'b1;
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_HDR;
      cnt_q      <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      pend_q     <= 1'b0;
      cur_fifo_q <= 1'b0;
      op_addr_q  <= '0;
      wdata_q    <= '0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      push_q     <= 1'b0;
      pop_q      <= 1'b0;
      load_q     <= 1'b0;
      sel_q      <= 1'b0;
      shift_q    <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      addr_q     <= addr_d;
      pend_q     <= pend_d;
      cur_fifo_q <= cur_fifo_d;
      op_addr_q  <= op_addr_d;
      wdata_q    <= wdata_d;
      wr_q       <= (wr_tgt_d == OP_REG);
      push_q     <= (wr_tgt_d == OP_FIFO);
      rd_q       <= (rd_tgt_d == OP_REG);
      pop_q      <= pop_d;
      load_q     <= load_d;
      sel_q      <= sel_d;
      shift_q    <= shift_d;
    end
  end

  assign op_addr     = op_addr_q;
  assign op_wdata    = wdata_q;
  assign reg_wr      = wr_q;
  assign reg_rd      = rd_q;
  assign fifo_push   = push_q;
  assign fifo_pop    = pop_q;
  assign rd_load     = load_q;
  assign rd_sel_fifo = sel_q;
  assign tx_shift    = shift_q;

  // R10: core-side strobes never overlap
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_q, rd_q, push_q, pop_q}) <= 1);

  // R2: one byte gives one single-cycle write strobe
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  // R5: the FIFO port address never produces a register write
  assert_no_reg_wr_fifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (op_addr_q != FIFO_ADDR));

  // R8: deselect returns the framing to the header start
  assert_deselect_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (cnt_q == '0 && phase_q == PH_HDR && !pend_q));

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              load,
  input  logic              shift,
  input  logic              sel_fifo,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              miso
);

  logic [DATA_W-1:0] sr_q, sr_d, src;
  logic              miso_q, miso_d;

  assign src = sel_fifo ? fifo_rdata : reg_rdata;

  always_comb begin
    sr_d   = sr_q;
    miso_d = miso_q;
    if (!cs_act) begin
      sr_d   = '0;
      miso_d = 1'b0;
    end else if (load) begin
      miso_d = src[DATA_W-1];
      sr_d   = {src[DATA_W-2:0], 1'b0};
    end else if (shift) begin
      miso_d = sr_q[DATA_W-1];
      sr_d   = {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      miso_q <= miso_d;
    end
  end

  assign miso = miso_q;

  // R8: data-out is parked low once the host deselects
  assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_q);

  // R3: a byte load and a bit shift never arrive together
  assert_load_shift_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] FIFO_ADDR   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_wr,
  output logic              rf_rd,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              fifo_push,
  output logic              fifo_pop,
  input  logic [DATA_W-1:0] fifo_rdata
);

  logic cs_act, sclk_rise, sclk_fall, mosi_s;
  logic rd_load, rd_sel_fifo, tx_shift;

  spi_in_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s)
  );

  spi_frame_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FIFO_ADDR (FIFO_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .mosi_s      (mosi_s),
    .op_addr     (rf_addr),
    .op_wdata    (rf_wdata),
    .reg_wr      (rf_wr),
    .reg_rd      (rf_rd),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .rd_load     (rd_load),
    .rd_sel_fifo (rd_sel_fifo),
    .tx_shift    (tx_shift)
  );

  spi_tx_shift #(
    .DATA_W (DATA_W)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .load       (rd_load),
    .shift      (tx_shift),
    .sel_fifo   (rd_sel_fifo),
    .reg_rdata  (rf_rdata),
    .fifo_rdata (fifo_rdata),
    .miso       (spi_miso)
  );

  assign spi_miso_oe = cs_act;

endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_sclk = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic [6:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata, fifo_rdata;
  logic       rf_wr, rf_rd, fifo_push, fifo_pop;

  int total = 0;
  int bad = 0;
  int pop_cnt = 0;
  int exp_pops = 0;
  bit done = 0;
  logic [16:0] exp_q[$];   // {kind[1:0], addr[6:0], data[7:0]}; kind 0=wr 1=push 2=pop

  always #2 clk = ~clk;

  function automatic logic [7:0] rv(input logic [6:0] a);
    return {1'b0, a} * 8'd3 + 8'h11;
  endfunction

  function automatic logic [7:0] fv(input int n);
    return 8'hC3 ^ 8'(n * 7);
  endfunction

  assign rf_rdata   = rv(rf_addr);
  assign fifo_rdata = fv(pop_cnt);

  always @(posedge clk) if (fifo_pop) pop_cnt <= pop_cnt + 1;

  spi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_wr(rf_wr), .rf_rd(rf_rd),
    .rf_rdata(rf_rdata), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare every write/push/pop strobe with the scoreboard
  always @(negedge clk) begin
    if (rst_n && (rf_wr || fifo_push || fifo_pop)) begin
      logic [1:0]  kind;
      logic [16:0] e;
      logic [16:0] got;
      kind = rf_wr ? 2'd0 : (fifo_push ? 2'd1 : 2'd2);
      got  = {kind, rf_addr, (kind == 2'd2) ? 8'h00 : rf_wdata};
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R7 unexpected strobe", int'(got), 0);
      end else begin
        e = exp_q.pop_front();
        check(got == e, (kind == 2'd0) ? "R2/R4 write" : (kind == 2'd1) ? "R5 push" : "R6 pop",
              int'(got), int'(e));
      end
    end
  end

  task automatic sbit(input logic mo, output logic mi);
    spi_mosi = mo;
    repeat (HALF) @(negedge clk);
    mi = spi_miso;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  // Driver: one transaction, nbytes full bytes then extra partial bits
  task automatic xfer(input bit wr, input logic [6:0] a, input int nbytes,
                      input int extra, input logic [7:0] seed, input string tag);
    logic [6:0] cur;
    logic [7:0] hdr, d, got, exp;
    logic       mi;
    cur = a;
    hdr = {wr, a};
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check(spi_miso_oe == 1'b1, "R8 oe active", spi_miso_oe, 1);
    for (int b = 7; b >= 0; b--) sbit(hdr[b], mi);   // R1 header
    for (int i = 0; i < nbytes; i++) begin
      if (wr) begin
        d = seed + 8'(i * 17);
        exp_q.push_back({(cur == 7'h7F) ? 2'd1 : 2'd0, cur, d});
        for (int b = 7; b >= 0; b--) sbit(d[b], mi);
      end else begin
        if (cur == 7'h7F) begin
          exp = fv(exp_pops);
          exp_q.push_back({2'd2, 7'h7F, 8'h00});
          exp_pops++;
        end else begin
          exp = rv(cur);
        end
        got = '0;
        for (int b = 7; b >= 0; b--) begin
          sbit(1'b1, mi);            // R3: ignored field held high
          got = {got[6:0], mi};
        end
        check(got == exp, (cur == 7'h7F) ? "R6 fifo read" : (i > 0) ? "R4 burst read" : "R3 read",
              got, exp);
      end
      cur = (cur == 7'h7F) ? cur : cur + 7'd1;
    end
    for (int b = 0; b < extra; b++) sbit(b[0], mi);
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    check(spi_miso == 1'b0 && spi_miso_oe == 1'b0, "R8 idle pins",
          {spi_miso, spi_miso_oe}, 0);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({rf_wr, rf_rd, fifo_push, fifo_pop, spi_miso, spi_miso_oe} == 6'b0,
          "R9 reset outputs", {rf_wr, rf_rd, fifo_push, fifo_pop, spi_miso, spi_miso_oe}, 0);

    xfer(1'b1, 7'h12, 1, 0, 8'h5A, "R1 single write");
    xfer(1'b1, 7'h20, 3, 0, 8'h81, "R4 burst write");
    xfer(1'b1, 7'h7E, 3, 0, 8'h3C, "R5 burst into fifo port");
    xfer(1'b1, 7'h7F, 2, 0, 8'hE7, "R5 fifo write burst");
    xfer(1'b1, 7'h30, 0, 5, 8'h00, "R7 partial write byte");
    xfer(1'b1, 7'h31, 1, 6, 8'h96, "R7 trailing partial byte");
    xfer(1'b0, 7'h05, 1, 0, 8'h00, "R3 read ignores data field");
    xfer(1'b0, 7'h3E, 3, 0, 8'h00, "R4 burst read");
    xfer(1'b0, 7'h7F, 3, 0, 8'h00, "R6 fifo read burst");
    xfer(1'b0, 7'h7F, 0, 4, 8'h00, "R6 partial fifo read");
    xfer(1'b0, 7'h7F, 1, 0, 8'h00, "R6 head kept after partial");
    xfer(1'b0, 7'h7D, 3, 0, 8'h00, "R4 read burst into fifo");
    check(pop_cnt == exp_pops, "R6 pop count", pop_cnt, exp_pops);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule